// File: doc/BRIEF.md
# Interval Timer Channel with Square-Wave Output

This block is one down-counting timer channel. Software loads a period value, picks whether a start should already count as an event, and then fires a one-cycle start trigger. The counter takes the period value and counts down by one on every cycle in which the external prescaler's tick input is high. When it is at zero on a tick, it reloads the period value, raises a one-cycle interrupt pulse and toggles its square-wave level. The interrupt therefore repeats every N+1 ticks for a period value N, and the square wave has a half-period of N+1 ticks.

A one-cycle stop trigger freezes the channel. The counter keeps its last value and the output keeps its level. Both stay readable until the next start. With output enable low, the pin shows a level that software writes directly. With output enable high, the pin follows the timer's toggling and software level writes are dropped.

Top module: `interval_sqw_timer`

## Requirements
- R1: While reset is asserted (rst_n low), count_o, running_o, irq_o and pin_o are 0, and the stored period and mode are 0.
- R2: A start trigger without a stop trigger sets running_o in the next cycle and loads count_o with the period value held before that edge.
- R3: With mode bit 1, a start trigger also produces a one-cycle irq_o and toggles the level at the same edge. With mode bit 0, a start produces no irq_o and no toggle.
- R4: While running, count_o decreases by 1 on each cycle with tick_i high and holds its value on cycles with tick_i low. count_o is readable at all times.
- R5: When count_o is 0 on a tick, the channel reloads the period, raises irq_o for one cycle and toggles the level. For a period value N, irq_o therefore occurs every N+1 ticks.
- R6: A stop trigger clears running_o. Afterwards count_o and pin_o keep their values, and no further irq_o occurs, until the next start.
- R7: When start and stop triggers arrive in the same cycle, stop wins: the channel ends up stopped with no load and no irq_o.
- R8: A start trigger while the channel is running restarts it. The period is reloaded and the R3 start behaviour applies again.
- R9: A period write while the channel is running does not change the count in progress. The new value is used at the next reload or start.
- R10: A mode write while running_o is 1 is ignored, which can be seen on the next restart. A mode write while stopped is stored.
- R11: With out_en_i 0, a level write sets pin_o on the next cycle and timer events do not toggle it. With out_en_i 1, level writes are ignored and pin_o toggles on each event, in the same cycle that irq_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | Count enable from the external prescaler |
| period_wr_i | input | 1 | Write strobe for the period register |
| period_i | input | W | New period value |
| mode_wr_i | input | 1 | Write strobe for the mode bit |
| mode_i | input | 1 | Mode bit: 1 makes a start count as an event |
| start_i | input | 1 | One-cycle start trigger |
| stop_i | input | 1 | One-cycle stop trigger |
| out_en_i | input | 1 | 1: pin follows timer toggles; 0: pin follows the software level |
| lvl_wr_i | input | 1 | Write strobe for the software output level |
| lvl_i | input | 1 | Software output level |
| count_o | output | W | Live counter value |
| running_o | output | 1 | Channel enabled status |
| irq_o | output | 1 | One-cycle interrupt pulse |
| pin_o | output | 1 | Square-wave or software output level |

## Verification
Directed sequences come first. A period of 3 counted over many ticks separates the N+1 reload spacing from an off-by-one spacing of N. A start in each mode separates an event on start from a silent start. Simultaneous start and stop shows which one has priority. A period rewrite in mid-count, and a mode write while running followed by a restart, show whether a new value is applied early or applied at all. After that, thousands of cycles of seeded random ticks, triggers, register writes and output-enable changes are compared every cycle against a reference model. This exposes interactions that the directed cases do not reach, such as stops at zero count, back-to-back events with period 0, and level writes racing toggles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_LOAD = 2'd1,
    CNT_DEC  = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick_i,
  input  logic    start_i,
  input  logic    stop_i,
  input  logic    mode_wr_i,
  input  logic    mode_i,
  input  logic    zero_i,
  output logic    run_o,
  output logic    mode_o,
  output cnt_op_e op_o,
  output logic    evt_o
);
  logic run_q, run_d;
  logic mode_q, mode_d;
  logic go;

  // stop has priority over start
  assign go = start_i & ~stop_i;

  always_comb begin
    run_d = run_q;
    if (stop_i)       run_d = 1'b0;
    else if (start_i) run_d = 1'b1;
  end

  always_comb begin
    mode_d = mode_q;
    if (mode_wr_i && !run_q) mode_d = mode_i;
  end

  always_comb begin
    op_o  = CNT_HOLD;
    evt_o = 1'b0;
    if (stop_i) begin
      op_o = CNT_HOLD;
    end else if (start_i) begin
      op_o  = CNT_LOAD;
      evt_o = mode_q;
    end else if (run_q && tick_i) begin
      if (zero_i) begin
        op_o  = CNT_LOAD;
        evt_o = 1'b1;
      end else begin
        op_o = CNT_DEC;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      mode_q <= mode_d;
    end
  end

  assign run_o  = run_q;
  assign mode_o = mode_q;

  logic unused_go;
  assign unused_go = go;
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_op_e      op_i,
  input  logic         period_wr_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] period_o,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] per_q, per_d;

  always_comb begin
    per_d = per_q;
    if (period_wr_i) per_d = period_i;
  end

  // reload uses the period held before this edge
  always_comb begin
    unique case (op_i)
      CNT_LOAD: cnt_d = per_q;
      CNT_DEC:  cnt_d = cnt_q - ONE;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign period_o = per_q;
  assign zero_o   = (cnt_q == '0);
endmodule

// File: rtl/tmr_pin.sv
module tmr_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic oe_i,
  input  logic lvl_wr_i,
  input  logic lvl_i,
  output logic pin_o,
  output logic irq_o
);
  logic lvl_q, lvl_d;
  logic irq_q;

  always_comb begin
    lvl_d = lvl_q;
    if (oe_i) begin
      if (evt_i) lvl_d = ~lvl_q;
    end else if (lvl_wr_i) begin
      lvl_d = lvl_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      irq_q <= evt_i;
    end
  end

  assign pin_o = lvl_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/interval_sqw_timer.sv
module interval_sqw_timer
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         period_wr_i,
  input  logic [W-1:0] period_i,
  input  logic         mode_wr_i,
  input  logic         mode_i,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         out_en_i,
  input  logic         lvl_wr_i,
  input  logic         lvl_i,
  output logic [W-1:0] count_o,
  output logic         running_o,
  output logic         irq_o,
  output logic         pin_o
);
  cnt_op_e      op;
  logic         evt;
  logic         zero;
  logic         mode_q;
  logic [W-1:0] period_q;

  tmr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .mode_wr_i (mode_wr_i),
    .mode_i    (mode_i),
    .zero_i    (zero),
    .run_o     (running_o),
    .mode_o    (mode_q),
    .op_o      (op),
    .evt_o     (evt)
  );

  tmr_count #(.W(W)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op),
    .period_wr_i (period_wr_i),
    .period_i    (period_i),
    .period_o    (period_q),
    .cnt_o       (count_o),
    .zero_o      (zero)
  );

  tmr_pin u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt),
    .oe_i     (out_en_i),
    .lvl_wr_i (lvl_wr_i),
    .lvl_i    (lvl_i),
    .pin_o    (pin_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/interval_sqw_timer_chk.sv
module interval_sqw_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_i,
  input logic         start_i,
  input logic         stop_i,
  input logic         out_en_i,
  input logic [W-1:0] count_o,
  input logic         running_o,
  input logic         irq_o,
  input logic         pin_o,
  input logic         mode_q,
  input logic [W-1:0] period_q
);
  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> (running_o && count_o == $past(period_q)));

  // R6
  stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!running_o && !irq_o && $stable(count_o)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !start_i) |=> $stable(count_o));

  // R4
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && tick_i && !start_i && !stop_i && count_o != '0)
      |=> (count_o == $past(count_o) - W'(1)));

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && !tick_i && !start_i && !stop_i) |=> $stable(count_o));

  // R10
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |=> $stable(mode_q));

  // R11
  pin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_i |=> ((pin_o ^ $past(pin_o)) == irq_o));

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (count_o == '0 && !running_o && !irq_o && !pin_o);
    end
  end
endmodule

bind interval_sqw_timer interval_sqw_timer_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .start_i   (start_i),
  .stop_i    (stop_i),
  .out_en_i  (out_en_i),
  .count_o   (count_o),
  .running_o (running_o),
  .irq_o     (irq_o),
  .pin_o     (pin_o),
  .mode_q    (mode_q),
  .period_q  (period_q)
);

// File: tb/sim_interval_sqw_timer.sv
`timescale 1ns/1ps
module sim_interval_sqw_timer;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic tick, pwr, mwr, mdat, st, sp, oe, lwr, ldat;
  logic [W-1:0] pdat;
  logic [W-1:0] count;
  logic running, irq, pin;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state (expected outputs after the next edge)
  logic [W-1:0] m_cnt, m_per;
  logic m_run, m_mode, m_lvl, m_irq;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  interval_sqw_timer #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .period_wr_i(pwr), .period_i(pdat),
    .mode_wr_i(mwr), .mode_i(mdat), .start_i(st), .stop_i(sp), .out_en_i(oe),
    .lvl_wr_i(lwr), .lvl_i(ldat), .count_o(count), .running_o(running),
    .irq_o(irq), .pin_o(pin)
  );

  function automatic logic m_evt();
    return !sp && ((st && m_mode) || (m_run && !st && tick && m_cnt == '0));
  endfunction

  task automatic model_step();
    logic e;
    logic [W-1:0] c;
    e = m_evt();
    c = m_cnt;
    if (!sp) begin
      if (st) c = m_per;
      else if (m_run && tick) c = (m_cnt == '0) ? m_per : m_cnt - 1;
    end
    m_cnt = c;
    if (oe) begin
      if (e) m_lvl = ~m_lvl;
    end else if (lwr) m_lvl = ldat;
    if (mwr && !m_run) m_mode = mdat;
    if (pwr) m_per = pdat;
    m_run = sp ? 1'b0 : (st ? 1'b1 : m_run);
    m_irq = e;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic idle();
    tick = 0; pwr = 0; pdat = '0; mwr = 0; mdat = 0; st = 0; sp = 0; lwr = 0; ldat = 0;
  endtask

  // inputs are set by the caller; advance one cycle and compare
  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "count", int'(count), int'(m_cnt));
    chk(tag, "running", int'(running), int'(m_run));
    chk(tag, "irq", int'(irq), int'(m_irq));
    chk(tag, "pin", int'(pin), int'(m_lvl));
    idle();
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int irqs;
    void'($urandom(32'h5EED_0042));
    idle(); oe = 0; rst_n = 0;
    m_cnt = '0; m_per = '0; m_run = 0; m_mode = 0; m_lvl = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "count", int'(count), 0);
    chk("R1", "running", int'(running), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "pin", int'(pin), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 / R3 mode 0 start
    pwr = 1; pdat = 16'd3; step("R9");
    oe = 1; st = 1; step("R2");
    chk("R2", "count after start", int'(count), 3);
    chk("R3", "irq on mode0 start", int'(irq), 0);
    // R4 / R5 period 3 gives irq every 4 ticks
    irqs = 0;
    for (int i = 0; i < 40; i++) begin
      tick = 1; step("R5");
      if (irq) irqs++;
    end
    chk("R5", "irq count over 40 ticks", irqs, 10);
    // R4 hold without tick
    for (int i = 0; i < 5; i++) step("R4");
    // R9 rewrite period mid-count
    tick = 1; step("R4");
    pwr = 1; pdat = 16'd6; step("R9");
    for (int i = 0; i < 20; i++) begin tick = 1; step("R9"); end
    // R10 mode write while running ignored, seen at restart
    mwr = 1; mdat = 1; step("R10");
    st = 1; step("R8");
    chk("R10", "irq on restart after ignored mode write", int'(irq), 0);
    // R6 stop holds count and pin
    tick = 1; step("R4");
    sp = 1; tick = 1; step("R6");
    for (int i = 0; i < 8; i++) begin tick = 1; step("R6"); end
    // R10 mode write while stopped accepted, R3 start irq
    mwr = 1; mdat = 1; step("R10");
    st = 1; step("R3");
    chk("R3", "irq on mode1 start", int'(irq), 1);
    // R8 restart while running fires again
    tick = 1; step("R4");
    st = 1; step("R8");
    chk("R8", "irq on restart", int'(irq), 1);
    // R7 start and stop together
    st = 1; sp = 1; step("R7");
    chk("R7", "running", int'(running), 0);
    // R11 software level with oe low, toggles suppressed
    oe = 0; lwr = 1; ldat = ~pin; step("R11");
    st = 1; step("R11");
    for (int i = 0; i < 30; i++) begin tick = 1; step("R11"); end
    oe = 1; lwr = 1; ldat = ~pin; step("R11");
    pwr = 1; pdat = 16'd0; step("R9");
    st = 1; step("R5");
    for (int i = 0; i < 6; i++) begin tick = 1; step("R5"); end

    // random phase
    for (int i = 0; i < 4000; i++) begin
      tick = ($urandom % 2) == 0;
      st   = ($urandom % 16) == 0;
      sp   = ($urandom % 20) == 0;
      pwr  = ($urandom % 10) == 0;
      pdat = W'($urandom % 8);
      mwr  = ($urandom % 10) == 0;
      mdat = $urandom % 2;
      lwr  = ($urandom % 8) == 0;
      ldat = $urandom % 2;
      if (($urandom % 50) == 0) oe = ~oe;
      step("R4/R5/R11 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule